// File: doc/BRIEF.md
# Dual-Mode Per-Processor Timer Bank

This block holds one system timer plus one timer for each processor, all reached through a single word-addressed register port. Each per-processor timer runs in one of two modes, chosen at run time. In counter mode it counts up to a 32-bit limit, wraps to zero and raises its interrupt. In user mode it is a free-running 64-bit counter that software loads and reads as two words. The system timer always stays in counter mode, and it is the only path through which the mode register can be written.

A timer advances only in cycles where the shared tick-enable input is high and the timer is in a running state. Each timer is controlled by a four-state machine: `T_CNT_RUN`, `T_CNT_HALT`, `T_USR_RUN` and `T_USR_HALT`. The transitions are:
- *halt*: `T_CNT_RUN`→`T_CNT_HALT` and `T_USR_RUN`→`T_USR_HALT`, on a control write with bit 0 clear.
- *resume*: the reverse moves, on a control write with bit 0 set.
- *enter-user*: `T_CNT_RUN`→`T_USR_RUN` and `T_CNT_HALT`→`T_USR_HALT`, on a mode-bit rise.
- *leave-user*: either user state goes to `T_CNT_RUN` on a mode-bit fall.

The run state is therefore kept through enter-user, and leave-user always starts the timer.

Top module: `cpu_tick_timer_bank`

## Requirements
- R1: The register is picked by the byte address shifted right by two, so address bits 1:0 are ignored. Word 0 is limit/upper, 1 is count/lower, 2 is limit-keep, 3 is control, 4 is mode. Word indices 5 to 7, and timer selects at or above NUM_CPUS+1, are ignored on write and read as zero. Read data appears on `bus_rdata_o` one cycle after the read strobe and reflects the state before that cycle's updates.
- R2: After reset every timer is in `T_CNT_RUN` with count 0, limit 0, reached flag 0 and interrupt low, and the mode register reads 0.
- R3: In counter mode, each advance first forms count+1 in the low word. When count+1 is at least the effective limit (the limit, or 2^32 when the limit is 0), the low word goes to 0 and the reached flag and interrupt are set. Otherwise the low word becomes count+1.
- R4: In counter mode, a write to word 0 loads the limit, clears the whole count, and clears the reached flag and the interrupt.
- R5: A write to word 2 replaces the limit and leaves the count unchanged. Zero again selects free-run.
- R6: In counter mode, a write to word 1 has no effect at all.
- R7: In user mode, a write to word 0 loads the upper 32 bits of the count and a write to word 1 loads the lower 32 bits. Both clear the reached flag. The 64-bit count advances by one per advance, and the interrupt stays low. A read of word 0 returns the upper word.
- R8: A write to word 3 sets the running state from bit 0 and does not change the mode. Word 3 reads back with bit 0 = running, bit 1 = reached and bit 2 = user mode.
- R9: Mode bit i belongs to timer i+1. The mode register is written only through timer select 0, and a mode write through any other select leaves every timer unchanged. The system timer never leaves counter mode.
- R10: Only mode bits that differ from the current mode act. Entering user mode drops the interrupt, sets the limit to zero (full range) and keeps the run state. Leaving user mode puts the timer in `T_CNT_RUN`.
- R11: In counter mode, a read of word 0 returns the low count word and clears the reached flag and the interrupt. If a wrap happens in the same cycle, the wrap's set wins.
- R12: An accepted write that targets a timer (words 0 to 3, or a mode change of that timer) takes the place of that timer's tick in that cycle. An ignored counter-mode write to word 1 does not.
- R13: Word 1 always reads the low count word, and word 2 reads the stored limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe shared by all timers |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_sel_i | input | SEL_W | Timer select (0 = system timer) |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | WORD_W | Write data |
| bus_rdata_o | output | WORD_W | Registered read data |
| irq_o | output | NUM_CPUS+1 | Interrupt per timer, bit 0 = system timer |

## Verification
Counting is driven with a steady tick, with a tick on every other cycle, and with no tick at all. This separates advancing on the tick from advancing on the clock, and it checks that a halted timer holds its count. Limits of 1, 3, 5, a limit-keep value below the current count, and zero (free-run reached by loading a count near 2^32 in user mode and switching back) show that the wrap point follows the stored limit. In user mode, loading the lower word just under its maximum shows the carry into the upper word. Writes that coincide with ticks, a read-clear in the cycle of a wrap, and mode writes that repeat the current value show the precedence rules.

// File: rtl/cttb_pkg.sv
`timescale 1ns/1ps
package cttb_pkg;

    // Per-timer control states: mode (counter/user) crossed with run/halt.
    typedef enum logic [1:0] {
        T_CNT_RUN  = 2'd0,
        T_CNT_HALT = 2'd1,
        T_USR_RUN  = 2'd2,
        T_USR_HALT = 2'd3
    } tmr_state_e;

    // Register word index (byte address >> 2).
    typedef enum logic [2:0] {
        RG_LIMIT = 3'd0,
        RG_COUNT = 3'd1,
        RG_KEEP  = 3'd2,
        RG_CTRL  = 3'd3,
        RG_MODE  = 3'd4
    } reg_idx_e;

    // Decoded per-timer command for one cycle.
    typedef struct packed {
        logic wr_limit;
        logic wr_count;
        logic wr_keep;
        logic wr_ctrl;
        logic rd_limit;
        logic to_user;
        logic to_count;
    } tmr_cmd_t;

endpackage

// File: rtl/cttb_decode.sv
`timescale 1ns/1ps
module cttb_decode
    import cttb_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int NUM_TIMERS = NUM_CPUS + 1,
    parameter int SEL_W = 2,
    parameter int ADDR_W = 5
) (
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [SEL_W-1:0]      bus_sel_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [NUM_CPUS-1:0]   mode_bits_i,
    input  logic [NUM_TIMERS-1:0] user_i,
    output tmr_cmd_t              cmd_o [NUM_TIMERS],
    output logic                  mode_wr_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             sel_ok;
    logic             unused_ok;

    assign idx       = bus_addr_i[ADDR_W-1:2];
    assign sel_ok    = ({1'b0, bus_sel_i} < (SEL_W+1)'(NUM_TIMERS));
    assign mode_wr_o = bus_wr_i && (bus_sel_i == '0) && (idx == IDX_W'(RG_MODE));
    assign unused_ok = ^{bus_addr_i[1:0], user_i[0]};

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_cmd
        logic     hit;
        tmr_cmd_t c;
        assign hit = sel_ok && (bus_sel_i == SEL_W'(t));
        always_comb begin
            c          = '0;
            c.wr_limit = bus_wr_i && hit && (idx == IDX_W'(RG_LIMIT));
            c.wr_count = bus_wr_i && hit && (idx == IDX_W'(RG_COUNT));
            c.wr_keep  = bus_wr_i && hit && (idx == IDX_W'(RG_KEEP));
            c.wr_ctrl  = bus_wr_i && hit && (idx == IDX_W'(RG_CTRL));
            c.rd_limit = bus_rd_i && hit && (idx == IDX_W'(RG_LIMIT));
        end
        if (t == 0) begin : g_sys
            assign cmd_o[t] = c;
        end else begin : g_cpu
            tmr_cmd_t cm;
            always_comb begin
                cm          = c;
                cm.to_user  = mode_wr_o &&  mode_bits_i[t-1] && !user_i[t];
                cm.to_count = mode_wr_o && !mode_bits_i[t-1] &&  user_i[t];
            end
            assign cmd_o[t] = cm;
        end
    end

endmodule

// File: rtl/cttb_unit.sv
`timescale 1ns/1ps
module cttb_unit
    import cttb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter bit IS_SYS = 1'b0,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  tmr_cmd_t          cmd_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [WORD_W-1:0] limit_o,
    output logic              reached_o,
    output logic              irq_o,
    output logic              run_o,
    output logic              user_o
);

    tmr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [WORD_W-1:0] limit_q, limit_d;
    logic              reached_q, reached_d;
    logic              irq_q, irq_d;
    logic              is_user, is_run, busy, adv, hit;
    logic [WORD_W:0]   lo_inc, lim_eff;

    // ---------------- state register ----------------
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= T_CNT_RUN;
        else         state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_CNT_RUN: begin
                if (cmd_i.to_user)                     state_d = T_USR_RUN;   // enter-user
                else if (cmd_i.wr_ctrl && !wdata_i[0]) state_d = T_CNT_HALT;  // halt
            end
            T_CNT_HALT: begin
                if (cmd_i.to_user)                     state_d = T_USR_HALT;  // enter-user
                else if (cmd_i.wr_ctrl && wdata_i[0])  state_d = T_CNT_RUN;   // resume
            end
            T_USR_RUN: begin
                if (cmd_i.to_count)                    state_d = T_CNT_RUN;   // leave-user
                else if (cmd_i.wr_ctrl && !wdata_i[0]) state_d = T_USR_HALT;  // halt
            end
            T_USR_HALT: begin
                if (cmd_i.to_count)                    state_d = T_CNT_RUN;   // leave-user
                else if (cmd_i.wr_ctrl && wdata_i[0])  state_d = T_USR_RUN;   // resume
            end
            default: state_d = T_CNT_RUN;
        endcase
    end

    // ---------------- datapath ----------------
    assign is_user = (state_q == T_USR_RUN) || (state_q == T_USR_HALT);
    assign is_run  = (state_q == T_CNT_RUN) || (state_q == T_USR_RUN);
    assign busy    = cmd_i.wr_limit || (cmd_i.wr_count && is_user) || cmd_i.wr_keep ||
                     cmd_i.wr_ctrl || cmd_i.to_user || cmd_i.to_count;
    assign adv     = tick_i && is_run && !busy;
    assign lo_inc  = {1'b0, count_q[WORD_W-1:0]} + 1'b1;
    assign lim_eff = (limit_q == '0) ? {1'b1, {WORD_W{1'b0}}} : {1'b0, limit_q};
    assign hit     = (lo_inc >= lim_eff);

    always_comb begin
        count_d   = count_q;
        limit_d   = limit_q;
        reached_d = reached_q;
        irq_d     = irq_q;
        if (cmd_i.to_user) begin
            irq_d   = 1'b0;
            limit_d = '0;
        end
        if (cmd_i.wr_limit) begin
            if (is_user) begin
                count_d[CNT_W-1:WORD_W] = wdata_i;
                reached_d               = 1'b0;
            end else begin
                limit_d   = wdata_i;
                count_d   = '0;
                reached_d = 1'b0;
                irq_d     = 1'b0;
            end
        end
        if (cmd_i.wr_count && is_user) begin
            count_d[WORD_W-1:0] = wdata_i;
            reached_d           = 1'b0;
        end
        if (cmd_i.wr_keep) limit_d = wdata_i;
        if (cmd_i.rd_limit && !is_user) begin
            reached_d = 1'b0;
            irq_d     = 1'b0;
        end
        if (adv) begin
            if (is_user) begin
                count_d = count_q + CNT_W'(1);
            end else if (hit) begin
                count_d[WORD_W-1:0] = '0;
                reached_d           = 1'b1;
                irq_d               = 1'b1;
            end else begin
                count_d[WORD_W-1:0] = lo_inc[WORD_W-1:0];
            end
        end
    end

    // ---------------- output / data registers ----------------
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q   <= '0;
            limit_q   <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            count_q   <= count_d;
            limit_q   <= limit_d;
            reached_q <= reached_d;
            irq_q     <= irq_d;
        end
    end

    assign count_o   = count_q;
    assign limit_o   = limit_q;
    assign reached_o = reached_q;
    assign irq_o     = irq_q;
    assign run_o     = is_run;
    assign user_o    = is_user;

    // ---------------- assertions ----------------
    assert_irq_counter_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_q |-> !is_user);

    assert_irq_with_reached_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_q) |-> reached_q);

    assert_limit_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i.wr_limit && !is_user) |=> (count_q == '0 && !irq_q));

    assert_keep_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i.wr_keep |=> $stable(count_q));

    assert_ignore_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i.wr_count && !is_user && !tick_i) |=> $stable(count_q));

    assert_leave_user_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i.to_count |=> (state_q == T_CNT_RUN));

    if (IS_SYS) begin : g_sys_chk
        assert_sys_counter_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !is_user);
    end

endmodule

// File: rtl/cpu_tick_timer_bank.sv
`timescale 1ns/1ps
module cpu_tick_timer_bank
    import cttb_pkg::*;
#(
    parameter int NUM_CPUS = 2,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5,
    localparam int NUM_TIMERS = NUM_CPUS + 1,
    localparam int SEL_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [SEL_W-1:0]      bus_sel_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [WORD_W-1:0]     bus_wdata_i,
    output logic [WORD_W-1:0]     bus_rdata_o,
    output logic [NUM_TIMERS-1:0] irq_o
);

    localparam int CNT_W = 2 * WORD_W;
    localparam int IDX_W = ADDR_W - 2;

    tmr_cmd_t              cmd [NUM_TIMERS];
    logic                  mode_wr;
    logic [CNT_W-1:0]      cnt_a [NUM_TIMERS];
    logic [WORD_W-1:0]     lim_a [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] reached_v, run_v, user_v;
    logic [NUM_CPUS-1:0]   mode_v;
    logic [IDX_W-1:0]      rd_idx;
    logic                  rd_sel_ok;
    logic [WORD_W-1:0]     rd_word, rdata_q;

    cttb_decode #(
        .NUM_CPUS  (NUM_CPUS),
        .NUM_TIMERS(NUM_TIMERS),
        .SEL_W     (SEL_W),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .bus_wr_i   (bus_wr_i),
        .bus_rd_i   (bus_rd_i),
        .bus_sel_i  (bus_sel_i),
        .bus_addr_i (bus_addr_i),
        .mode_bits_i(bus_wdata_i[NUM_CPUS-1:0]),
        .user_i     (user_v),
        .cmd_o      (cmd),
        .mode_wr_o  (mode_wr)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        cttb_unit #(
            .WORD_W(WORD_W),
            .IS_SYS(t == 0)
        ) u_unit (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .tick_i   (tick_i),
            .cmd_i    (cmd[t]),
            .wdata_i  (bus_wdata_i),
            .count_o  (cnt_a[t]),
            .limit_o  (lim_a[t]),
            .reached_o(reached_v[t]),
            .irq_o    (irq_o[t]),
            .run_o    (run_v[t]),
            .user_o   (user_v[t])
        );
    end

    assign mode_v    = user_v[NUM_TIMERS-1:1];
    assign rd_idx    = bus_addr_i[ADDR_W-1:2];
    assign rd_sel_ok = ({1'b0, bus_sel_i} < (SEL_W+1)'(NUM_TIMERS));

    // Read mux: selected timer, selected word.
    always_comb begin
        rd_word = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (rd_sel_ok && (bus_sel_i == SEL_W'(t))) begin
                case (rd_idx)
                    IDX_W'(RG_LIMIT): rd_word = user_v[t] ? cnt_a[t][CNT_W-1:WORD_W]
                                                          : cnt_a[t][WORD_W-1:0];
                    IDX_W'(RG_COUNT): rd_word = cnt_a[t][WORD_W-1:0];
                    IDX_W'(RG_KEEP):  rd_word = lim_a[t];
                    IDX_W'(RG_CTRL):  rd_word = WORD_W'({user_v[t], reached_v[t], run_v[t]});
                    IDX_W'(RG_MODE):  rd_word = WORD_W'(mode_v);
                    default:          rd_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_word;
    end

    assign bus_rdata_o = rdata_q;

    assert_mode_guarded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_wr |=> $stable(mode_v));

    assert_sys_irq_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o[0]) |-> reached_v[0]);

endmodule

// File: tb/cpu_tick_timer_bank_tb_top.sv
`timescale 1ns/1ps
module cpu_tick_timer_bank_tb_top;

    localparam int NT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_tick = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [1:0]  b_sel = '0;
    logic [4:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int    errs = 0, checks = 0, cycles = 0;
    string cur_req = "R2", tag_q = "R2", rd_tag = "R2";

    // reference model state
    logic [63:0] m_cnt [NT];
    logic [31:0] m_lim [NT];
    bit          m_run [NT], m_user [NT], m_rch [NT], m_irq [NT];
    logic [31:0] exp_rd;
    bit          rd_chk = 1'b0;

    always #2.5 clk = ~clk;

    cpu_tick_timer_bank dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(b_tick), .bus_wr_i(b_wr), .bus_rd_i(b_rd),
        .bus_sel_i(b_sel), .bus_addr_i(b_addr), .bus_wdata_i(b_wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] model_read(input int s, input int idx);
        if (s >= NT) return 32'h0;
        case (idx)
            0: return m_user[s] ? m_cnt[s][63:32] : m_cnt[s][31:0];
            1: return m_cnt[s][31:0];
            2: return m_lim[s];
            3: return {29'h0, m_user[s], m_rch[s], m_run[s]};
            4: return {30'h0, m_user[2], m_user[1]};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        int idx;
        int s;
        bit used [NT];
        logic [32:0] nxt, eff;
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                m_cnt[t] = '0; m_lim[t] = '0; m_run[t] = 1; m_user[t] = 0;
                m_rch[t] = 0; m_irq[t] = 0;
            end
            rd_chk = 0;
        end else begin
            idx = int'(b_addr[4:2]);
            s = int'(b_sel);
            tag_q = cur_req;
            rd_chk = b_rd;
            if (b_rd) begin
                exp_rd = model_read(s, idx);
                rd_tag = cur_req;
            end
            for (int t = 0; t < NT; t++) used[t] = 0;
            if (b_rd && s < NT && idx == 0 && !m_user[s]) begin
                m_rch[s] = 0; m_irq[s] = 0;
            end
            if (b_wr && s < NT) begin
                case (idx)
                    0: begin
                        used[s] = 1;
                        if (m_user[s]) begin m_cnt[s][63:32] = b_wdata; m_rch[s] = 0; end
                        else begin m_lim[s] = b_wdata; m_cnt[s] = '0; m_rch[s] = 0; m_irq[s] = 0; end
                    end
                    1: if (m_user[s]) begin used[s] = 1; m_cnt[s][31:0] = b_wdata; m_rch[s] = 0; end
                    2: begin used[s] = 1; m_lim[s] = b_wdata; end
                    3: begin used[s] = 1; m_run[s] = b_wdata[0]; end
                    4: if (s == 0) begin
                        for (int i = 1; i < NT; i++) begin
                            if (b_wdata[i-1] != m_user[i]) begin
                                used[i] = 1;
                                if (b_wdata[i-1]) begin m_user[i] = 1; m_irq[i] = 0; m_lim[i] = '0; end
                                else begin m_user[i] = 0; m_run[i] = 1; end
                            end
                        end
                    end
                    default: ;
                endcase
            end
            for (int t = 0; t < NT; t++) begin
                if (b_tick && m_run[t] && !used[t]) begin
                    if (m_user[t]) m_cnt[t] = m_cnt[t] + 64'd1;
                    else begin
                        nxt = {1'b0, m_cnt[t][31:0]} + 33'd1;
                        eff = (m_lim[t] == 0) ? 33'h1_0000_0000 : {1'b0, m_lim[t]};
                        if (nxt >= eff) begin m_cnt[t][31:0] = '0; m_rch[t] = 1; m_irq[t] = 1; end
                        else m_cnt[t][31:0] = nxt[31:0];
                    end
                end
            end
        end
    end

    // compare away from the active edge, every cycle
    always @(negedge clk) begin
        logic [2:0] exp_irq;
        if (rst_n) begin
            exp_irq = {m_irq[2], m_irq[1], m_irq[0]};
            checks++;
            if (irq !== exp_irq) begin
                errs++;
                $display("FAIL %s irq actual=%b expected=%b", tag_q, irq, exp_irq);
            end
            if (rd_chk) begin
                checks++;
                if (rdata !== exp_rd) begin
                    errs++;
                    $display("FAIL %s rdata actual=%h expected=%h", rd_tag, rdata, exp_rd);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errs++; checks++;
            $display("FAIL R12 watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic wr(input int s, input logic [4:0] a, input logic [31:0] d, input bit tk, input string r);
        @(negedge clk);
        cur_req = r; b_wr = 1; b_rd = 0; b_sel = 2'(s); b_addr = a; b_wdata = d; b_tick = tk;
    endtask

    task automatic rd(input int s, input logic [4:0] a, input bit tk, input string r);
        @(negedge clk);
        cur_req = r; b_wr = 0; b_rd = 1; b_sel = 2'(s); b_addr = a; b_tick = tk;
    endtask

    // pat: 0 = no tick, 1 = every cycle, 2 = every other cycle
    task automatic idle(input int n, input int pat, input string r);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur_req = r; b_wr = 0; b_rd = 0;
            b_tick = (pat == 1) || (pat == 2 && (k % 2 == 0));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        rd(0, 5'h0C, 0, "R2"); rd(1, 5'h0C, 0, "R2"); rd(2, 5'h0C, 0, "R2");
        rd(0, 5'h10, 0, "R2"); rd(1, 5'h04, 0, "R2"); rd(2, 5'h08, 0, "R2");
        // R4 / R13: limit load restarts count
        wr(1, 5'h00, 32'd5, 0, "R4");
        rd(1, 5'h04, 0, "R4"); rd(1, 5'h08, 0, "R13");
        // R3: steady ticks against limit 5
        idle(12, 1, "R3"); rd(1, 5'h04, 0, "R3"); rd(1, 5'h0C, 0, "R3");
        // R11: read-clear
        rd(1, 5'h00, 0, "R11"); idle(1, 0, "R11"); rd(1, 5'h0C, 0, "R11");
        // R3: gapped ticks on the system timer, limit 3
        wr(0, 5'h00, 32'd3, 0, "R3"); idle(14, 2, "R3"); rd(0, 5'h04, 0, "R3");
        // R8: halt and resume
        wr(0, 5'h0C, 32'd0, 1, "R8"); idle(6, 1, "R8");
        rd(0, 5'h0C, 0, "R8"); rd(0, 5'h04, 0, "R8");
        wr(0, 5'h0C, 32'd1, 1, "R8"); idle(3, 1, "R8"); rd(0, 5'h04, 0, "R8");
        // R6: counter write ignored in counter mode
        wr(2, 5'h04, 32'h1234, 0, "R6"); rd(2, 5'h04, 0, "R6"); rd(2, 5'h0C, 0, "R6");
        // R5: limit-keep
        wr(1, 5'h00, 32'd0, 0, "R5"); idle(10, 1, "R5");
        wr(1, 5'h08, 32'd100, 0, "R5"); rd(1, 5'h04, 0, "R5");
        idle(5, 1, "R5"); wr(1, 5'h08, 32'd3, 0, "R5");
        rd(1, 5'h04, 0, "R5"); idle(2, 1, "R5"); rd(1, 5'h04, 0, "R5");
        rd(1, 5'h00, 0, "R11");
        // R9: mode write through a non-system select is ignored
        wr(1, 5'h10, 32'd3, 0, "R9"); rd(0, 5'h10, 0, "R9"); rd(2, 5'h0C, 0, "R9");
        // R10: enter user mode, run state kept
        wr(2, 5'h0C, 32'd0, 0, "R10");
        wr(0, 5'h10, 32'd3, 1, "R10");
        rd(1, 5'h0C, 0, "R10"); rd(2, 5'h0C, 0, "R10"); rd(1, 5'h08, 0, "R10");
        idle(3, 1, "R10"); rd(2, 5'h04, 0, "R10"); rd(0, 5'h10, 0, "R10");
        // R7: user-mode words and carry
        wr(1, 5'h00, 32'd7, 0, "R7"); wr(1, 5'h04, 32'hFFFF_FFFE, 0, "R7");
        idle(4, 1, "R7"); rd(1, 5'h00, 0, "R7"); rd(1, 5'h04, 0, "R7"); rd(1, 5'h0C, 0, "R7");
        // R10: repeated mode value changes nothing
        wr(0, 5'h10, 32'd3, 1, "R10"); rd(1, 5'h04, 0, "R10");
        // R12: write replaces the tick
        wr(1, 5'h0C, 32'd1, 1, "R12"); rd(1, 5'h04, 0, "R12");
        wr(1, 5'h08, 32'd9, 1, "R12"); rd(1, 5'h04, 0, "R12");
        // R3: free-run wrap at 2^32 after leaving user mode
        wr(1, 5'h04, 32'hFFFF_FFF0, 0, "R3");
        wr(0, 5'h10, 32'd2, 0, "R10"); wr(1, 5'h08, 32'd0, 0, "R5");
        idle(20, 1, "R3"); rd(1, 5'h0C, 0, "R3"); rd(1, 5'h00, 0, "R11");
        // R1: address decode
        wr(2, 5'h0B, 32'd55, 0, "R1"); rd(2, 5'h0A, 0, "R1");
        wr(2, 5'h18, 32'd9, 0, "R1"); rd(2, 5'h18, 0, "R1"); rd(3, 5'h08, 0, "R1");
        // R11: wrap set wins over same-cycle read-clear
        wr(0, 5'h00, 32'd1, 0, "R11"); idle(2, 1, "R11");
        rd(0, 5'h00, 1, "R11"); idle(2, 0, "R11"); rd(0, 5'h0C, 0, "R11");
        idle(3, 0, "R2");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule